// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Decoder

This block sits on the device side of an 8-bit NAND flash bus and turns the raw, asynchronous strobe activity into clean single-cycle events for the logic behind it. All bus pins are brought into the system clock domain through a synchronizer chain. The write and read strobes then pass through a minimum-width filter, so pulses shorter than a configurable number of clocks never count as bus cycles.

Each accepted rising edge of the write strobe is classified from the control state captured just before that edge: chip select, command latch, address latch and read strobe. The outcome is a command byte, an address byte or a program-data byte, and anything else is discarded. Address bytes are packed, least significant first, into one wide word that is handed over once the last byte of the group arrives. For reads, the block drives a byte from an internal source onto the bus while the read strobe is low in a read state. When the read pulse ends, it signals the source to advance.

The block can act as the bus-facing front end of a flash model or as a passive monitor (with the output enable ignored).

Top module: `nfd_bus_decoder`

## Requirements
- R1: A write-strobe rising edge with select low, command latch high, address latch low and read strobe high produces a one-cycle `cmd_stb` carrying the bus byte on `cmd_code`.
- R2: A write-strobe rising edge with select low, address latch high, command latch low and read strobe high takes the bus byte as an address byte. After ADDR_BYTES such bytes, `addr_stb` pulses for one cycle, and `addr_word` holds the first byte in bits 7:0 and each later byte in the next higher byte lane.
- R3: The address byte count wraps after the last byte of a group, so the next address byte starts a new word.
- R4: A write-strobe rising edge with select, command latch and address latch all low and read strobe high produces a one-cycle `wr_stb` carrying the bus byte on `wr_byte`.
- R5: An accepted command byte clears the address byte count, so any partial address group is abandoned.
- R6: A write strobe seen with select high, with both latch enables high, or with the read strobe low produces no strobe of any kind and leaves the address byte count unchanged.
- R7: In a read state (select low, both latch enables low, write strobe high), the end of each read-strobe pulse produces one `rd_adv` pulse. Outside a read state, read pulses produce none.
- R8: `bus_dq_oe` is high only while the read strobe is low in a read state. While it is high, `bus_dq_o` holds steady at the `rd_byte` value present when driving began.
- R9: A strobe pulse that lasts fewer than FILT_CYC clocks after synchronization, including any pulse shorter than one clock, has no effect.
- R10: Every output event follows the bus edge that causes it by exactly SYNC_STAGES + FILT_CYC + 1 clocks, and every strobe lasts a single cycle.
- R11: During reset, all strobes and `bus_dq_oe` are low.
- R12: At most one of `cmd_stb`, `addr_stb` and `wr_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Device select, active low (asynchronous) |
| bus_cmd_lat | input | 1 | Command latch enable (asynchronous) |
| bus_adr_lat | input | 1 | Address latch enable (asynchronous) |
| bus_wr_n | input | 1 | Write strobe, active low (asynchronous) |
| bus_rd_n | input | 1 | Read strobe, active low (asynchronous) |
| bus_dq_i | input | DATA_W | Bus byte from the host |
| bus_dq_o | output | DATA_W | Byte driven to the host |
| bus_dq_oe | output | 1 | Drive enable for `bus_dq_o` |
| cmd_stb | output | 1 | Command byte received |
| cmd_code | output | DATA_W | Last command byte |
| addr_stb | output | 1 | Full address group received |
| addr_word | output | ADDR_BYTES*DATA_W | Assembled address |
| wr_stb | output | 1 | Program-data byte received |
| wr_byte | output | DATA_W | Last program-data byte |
| rd_byte | input | DATA_W | Next byte from the internal read source |
| rd_adv | output | 1 | Read source should advance |

## Verification
The checker watches, on every clock, that the three write-side strobes never coincide and that each lasts one cycle. It also checks that the address byte index stays in range and returns to zero on a command and on a completed group, that the driven byte holds steady while enabled, and that an advance pulse only follows a cycle in which the driver was on. Only the bench scenarios can show that classification picks the right class for each control state. The same holds for discarded strobes leaving the address count alone, for glitches shorter than the filter width being dropped, and for the exact latency from a pin edge. The bench shows these by checking every output against a timed expectation on every cycle.

// File: rtl/nfd_pkg.sv
`timescale 1ns/1ps
package nfd_pkg;

  // Kind of write-side bus cycle
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2,
    CYC_DIN  = 2'd3
  } nfd_cyc_e;

  // Control pins captured ahead of a write-strobe rising edge
  typedef struct packed {
    logic sel_n;
    logic cmd_lat;
    logic adr_lat;
    logic rd_n;
  } nfd_ctl_t;

  localparam nfd_ctl_t NFD_CTL_IDLE = '{sel_n: 1'b1, cmd_lat: 1'b0, adr_lat: 1'b0, rd_n: 1'b1};

  // Deselected, both latches high or read strobe low: discarded
  function automatic nfd_cyc_e nfd_classify(input nfd_ctl_t c);
    nfd_cyc_e k;
    if (c.sel_n || !c.rd_n || (c.cmd_lat && c.adr_lat)) k = CYC_NONE;
    else if (c.cmd_lat)                                 k = CYC_CMD;
    else if (c.adr_lat)                                 k = CYC_ADDR;
    else                                                k = CYC_DIN;
    return k;
  endfunction

endpackage

// File: rtl/nfd_sync.sv
`timescale 1ns/1ps
module nfd_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nfd_deglitch.sv
`timescale 1ns/1ps
module nfd_deglitch #(
  parameter int FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic rise
);

  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt;

  // Level follows raw only after FILT_CYC consecutive disagreeing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b1;
      cnt  <= '0;
      rise <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (raw == lvl) begin
        cnt <= '0;
      end else if (cnt == LIMIT) begin
        lvl  <= raw;
        cnt  <= '0;
        rise <= raw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nfd_wr_path.sv
`timescale 1ns/1ps
module nfd_wr_path
  import nfd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 5,
  localparam int AW        = ADDR_BYTES * DATA_W,
  localparam int IW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_rise,
  input  nfd_ctl_t          ctl,
  input  logic [DATA_W-1:0] dq,
  output logic              cmd_stb,
  output logic [DATA_W-1:0] cmd_code,
  output logic              addr_stb,
  output logic [AW-1:0]     addr_word,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_byte,
  output logic [IW-1:0]     addr_idx
);

  localparam logic [IW-1:0] LAST = IW'(ADDR_BYTES - 1);

  nfd_cyc_e     kind;
  logic [AW-1:0] asm_q;
  logic [AW-1:0] asm_nx;

  assign kind = nfd_classify(ctl);

  // Byte lanes fill from the top and shift down, so the first byte ends low
  generate
    if (ADDR_BYTES > 1) begin : g_multi
      assign asm_nx = {dq, asm_q[AW-1:DATA_W]};
    end else begin : g_single
      assign asm_nx = dq;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb   <= 1'b0;
      cmd_code  <= '0;
      addr_stb  <= 1'b0;
      addr_word <= '0;
      wr_stb    <= 1'b0;
      wr_byte   <= '0;
      addr_idx  <= '0;
      asm_q     <= '0;
    end else begin
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      wr_stb   <= 1'b0;
      if (we_rise) begin
        unique case (kind)
          CYC_CMD: begin
            cmd_stb  <= 1'b1;
            cmd_code <= dq;
            addr_idx <= '0;
          end
          CYC_ADDR: begin
            asm_q <= asm_nx;
            if (addr_idx == LAST) begin
              addr_stb  <= 1'b1;
              addr_word <= asm_nx;
              addr_idx  <= '0;
            end else begin
              addr_idx <= addr_idx + 1'b1;
            end
          end
          CYC_DIN: begin
            wr_stb  <= 1'b1;
            wr_byte <= dq;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nfd_rd_path.sv
`timescale 1ns/1ps
module nfd_rd_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re_rise,
  input  logic              re_lvl,
  input  logic              we_lvl,
  input  logic              sel_n,
  input  logic              cmd_lat,
  input  logic              adr_lat,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rd_adv
);

  logic rd_state;

  assign rd_state = !sel_n && !cmd_lat && !adr_lat && we_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o   <= '0;
      dq_oe  <= 1'b0;
      rd_adv <= 1'b0;
    end else begin
      dq_oe  <= rd_state && !re_lvl;
      // Advance only for a pulse whose byte was actually driven
      rd_adv <= re_rise && dq_oe;
      // Output byte frozen while driving, tracks the source otherwise
      if (!dq_oe) dq_o <= rd_byte;
    end
  end

endmodule

// File: rtl/nfd_bus_decoder.sv
`timescale 1ns/1ps
module nfd_bus_decoder
  import nfd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_BYTES  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel_n,
  input  logic                         bus_cmd_lat,
  input  logic                         bus_adr_lat,
  input  logic                         bus_wr_n,
  input  logic                         bus_rd_n,
  input  logic [DATA_W-1:0]            bus_dq_i,
  output logic [DATA_W-1:0]            bus_dq_o,
  output logic                         bus_dq_oe,
  output logic                         cmd_stb,
  output logic [DATA_W-1:0]            cmd_code,
  output logic                         addr_stb,
  output logic [ADDR_BYTES*DATA_W-1:0] addr_word,
  output logic                         wr_stb,
  output logic [DATA_W-1:0]            wr_byte,
  input  logic [DATA_W-1:0]            rd_byte,
  output logic                         rd_adv
);

  localparam int SW     = DATA_W + 5;
  localparam int IW     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int NSTB   = 2;
  localparam int STB_RD = 0;
  localparam int STB_WR = 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {DATA_W{1'b0}}};

  logic [SW-1:0]     pins_s;
  logic              we_s, rd_s, sel_s, cmd_s, adr_s;
  logic [DATA_W-1:0] dq_s;
  logic [NSTB-1:0]   stb_raw, stb_lvl, stb_rise;
  nfd_ctl_t          snap_ctl;
  logic [DATA_W-1:0] snap_dq;
  logic [IW-1:0]     addr_idx;

  nfd_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_wr_n, bus_rd_n, bus_sel_n, bus_cmd_lat, bus_adr_lat, bus_dq_i}),
    .q   (pins_s)
  );

  assign {we_s, rd_s, sel_s, cmd_s, adr_s, dq_s} = pins_s;

  assign stb_raw[STB_WR] = we_s;
  assign stb_raw[STB_RD] = rd_s;

  generate
    for (genvar g = 0; g < NSTB; g++) begin : g_filt
      nfd_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  (stb_raw[g]),
        .lvl  (stb_lvl[g]),
        .rise (stb_rise[g])
      );
    end
  endgenerate

  // Hold the bus state from the last sample with the write strobe low
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_ctl <= NFD_CTL_IDLE;
      snap_dq  <= '0;
    end else if (!we_s) begin
      snap_ctl <= '{sel_n: sel_s, cmd_lat: cmd_s, adr_lat: adr_s, rd_n: rd_s};
      snap_dq  <= dq_s;
    end
  end

  nfd_wr_path #(
    .DATA_W     (DATA_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .we_rise   (stb_rise[STB_WR]),
    .ctl       (snap_ctl),
    .dq        (snap_dq),
    .cmd_stb   (cmd_stb),
    .cmd_code  (cmd_code),
    .addr_stb  (addr_stb),
    .addr_word (addr_word),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte),
    .addr_idx  (addr_idx)
  );

  nfd_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .re_rise (stb_rise[STB_RD]),
    .re_lvl  (stb_lvl[STB_RD]),
    .we_lvl  (stb_lvl[STB_WR]),
    .sel_n   (sel_s),
    .cmd_lat (cmd_s),
    .adr_lat (adr_s),
    .rd_byte (rd_byte),
    .dq_o    (bus_dq_o),
    .dq_oe   (bus_dq_oe),
    .rd_adv  (rd_adv)
  );

endmodule

// File: rtl/nfd_bus_checker.sv
`timescale 1ns/1ps
module nfd_bus_checker #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 5,
  localparam int IW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_stb,
  input logic              addr_stb,
  input logic              wr_stb,
  input logic              rd_adv,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_o,
  input logic [IW-1:0]     addr_idx
);

  assert_one_class_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_stb, addr_stb, wr_stb}));

  assert_cmd_single_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    addr_idx < IW'(ADDR_BYTES));

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> addr_idx == '0);

  assert_cmd_clears_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> addr_idx == '0);

  assert_dq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

  assert_adv_after_drive_R7: assert property (@(posedge clk) disable iff (rst)
    rd_adv |-> ($past(dq_oe) && !dq_oe));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> !(cmd_stb || addr_stb || wr_stb || rd_adv || dq_oe));

endmodule

bind nfd_bus_decoder nfd_bus_checker #(
  .DATA_W     (DATA_W),
  .ADDR_BYTES (ADDR_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_stb  (cmd_stb),
  .addr_stb (addr_stb),
  .wr_stb   (wr_stb),
  .rd_adv   (rd_adv),
  .dq_oe    (bus_dq_oe),
  .dq_o     (bus_dq_o),
  .addr_idx (addr_idx)
);

// File: tb/tb_nfd_bus_decoder.sv
`timescale 1ns/1ps
module tb_nfd_bus_decoder;

  localparam int DW   = 8;
  localparam int AB   = 5;
  localparam int AW   = AB * DW;
  localparam int SYNC = 2;
  localparam int FILT = 2;
  localparam int LAT  = SYNC + FILT + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          sel_n = 1'b1, cl = 1'b0, al = 1'b0, wn = 1'b1, rn = 1'b1;
  logic [DW-1:0] dqi = '0;
  logic [DW-1:0] dq_o, cmd_code, wr_byte, rd_byte;
  logic          dq_oe, cmd_stb, addr_stb, wr_stb, rd_adv;
  logic [AW-1:0] addr_word;

  nfd_bus_decoder #(.DATA_W(DW), .ADDR_BYTES(AB), .SYNC_STAGES(SYNC), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst(rst),
    .bus_sel_n(sel_n), .bus_cmd_lat(cl), .bus_adr_lat(al), .bus_wr_n(wn), .bus_rd_n(rn),
    .bus_dq_i(dqi), .bus_dq_o(dq_o), .bus_dq_oe(dq_oe),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .addr_stb(addr_stb), .addr_word(addr_word),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_byte(rd_byte), .rd_adv(rd_adv)
  );

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string scen = "R11";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] fval(input int k);
    return 8'hA5 ^ 8'(k * 37);
  endfunction

  // Internal read source
  int src_ptr = 0;
  always @(posedge clk) begin
    if (rst) src_ptr <= 0;
    else if (rd_adv) src_ptr <= src_ptr + 1;
  end
  assign rd_byte = fval(src_ptr);

  // Timed expectations, keyed by cycle
  logic [DW-1:0] e_cmd [int];
  logic [AW-1:0] e_addr[int];
  logic [DW-1:0] e_wr  [int];
  bit            e_adv [int];
  logic [DW-1:0] e_oe  [int];

  int            m_acnt = 0;
  logic [DW-1:0] m_abuf [AB];
  int            m_rdk = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at cycle %0d", req, scen, what, act, exp, cyc);
    end
  endtask

  // Reference classification of one write-strobe edge
  task automatic model_wr(input bit s, input bit c, input bit a, input bit r,
                          input logic [DW-1:0] b, input int t);
    logic [AW-1:0] w;
    if (s || (c && a) || !r) return;          // R6
    if (c) begin
      e_cmd[t] = b;                           // R1
      m_acnt = 0;                             // R5
    end else if (a) begin
      m_abuf[m_acnt] = b;                     // R2
      m_acnt++;
      if (m_acnt == AB) begin
        w = '0;
        for (int i = 0; i < AB; i++) w[i*DW +: DW] = m_abuf[i];
        e_addr[t] = w;
        m_acnt = 0;                           // R3
      end
    end else begin
      e_wr[t] = b;                            // R4
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; cl = 1'b0; al = 1'b0; wn = 1'b1; rn = 1'b1;
  endtask

  task automatic wr_cycle(input bit s, input bit c, input bit a, input bit r,
                          input logic [DW-1:0] b, input int low = 3);
    @(negedge clk);
    sel_n = s; cl = c; al = a; rn = r; dqi = b; wn = 1'b0;
    repeat (low) @(negedge clk);
    wn = 1'b1;
    if (low >= FILT) model_wr(s, c, a, r, b, cyc + LAT);   // R9, R10
    repeat (3) @(negedge clk);
    idle();
  endtask

  task automatic rd_pulse(input bit ok, input int low = 3);
    int n, m;
    @(negedge clk);
    sel_n = 1'b0; cl = !ok; al = 1'b0; wn = 1'b1; rn = 1'b0;
    n = cyc;
    repeat (low) @(negedge clk);
    rn = 1'b1;
    m = cyc;
    if (ok && low >= FILT) begin
      for (int t = n + LAT; t < m + LAT; t++) e_oe[t] = fval(m_rdk);   // R8
      e_adv[m + LAT] = 1'b1;                                        // R7
      m_rdk++;
    end
    repeat (4) @(negedge clk);
    idle();
  endtask

  // Compare every output against the expectation on every clock
  always @(negedge clk) begin
    bit x;
    if (!rst && !done) begin
      x = e_cmd.exists(cyc);
      chk(cmd_stb === x, "R1", "cmd_stb", 64'(cmd_stb), 64'(x));
      if (x) chk(cmd_code === e_cmd[cyc], "R1", "cmd_code", 64'(cmd_code), 64'(e_cmd[cyc]));
      x = e_addr.exists(cyc);
      chk(addr_stb === x, "R2", "addr_stb", 64'(addr_stb), 64'(x));
      if (x) chk(addr_word === e_addr[cyc], "R2", "addr_word", 64'(addr_word), 64'(e_addr[cyc]));
      x = e_wr.exists(cyc);
      chk(wr_stb === x, "R4", "wr_stb", 64'(wr_stb), 64'(x));
      if (x) chk(wr_byte === e_wr[cyc], "R4", "wr_byte", 64'(wr_byte), 64'(e_wr[cyc]));
      x = e_adv.exists(cyc);
      chk(rd_adv === x, "R7", "rd_adv", 64'(rd_adv), 64'(x));
      x = e_oe.exists(cyc);
      chk(dq_oe === x, "R8", "dq_oe", 64'(dq_oe), 64'(x));
      if (x) chk(dq_o === e_oe[cyc], "R8", "dq_o", 64'(dq_o), 64'(e_oe[cyc]));
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R10 watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // R11: quiet outputs while in reset
    repeat (4) @(negedge clk);
    chk(!(cmd_stb || addr_stb || wr_stb || rd_adv || dq_oe), "R11", "reset outputs",
        64'({cmd_stb, addr_stb, wr_stb, rd_adv, dq_oe}), 64'(0));
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1, R10: commands with several byte patterns
    scen = "R1";
    wr_cycle(0, 1, 0, 1, 8'h00);
    wr_cycle(0, 1, 0, 1, 8'h30);
    wr_cycle(0, 1, 0, 1, 8'hFF, FILT);        // minimum accepted width

    // R2, R4: one address group, then data bytes
    scen = "R2";
    wr_cycle(0, 1, 0, 1, 8'h80);
    for (int i = 0; i < AB; i++) wr_cycle(0, 0, 1, 1, 8'(8'h11 * (i + 1)));
    scen = "R4";
    wr_cycle(0, 0, 0, 1, 8'h5A);
    wr_cycle(0, 0, 0, 1, 8'hC3);
    wr_cycle(0, 0, 0, 1, 8'h01, FILT);

    // R3: two back-to-back groups after one command
    scen = "R3";
    wr_cycle(0, 1, 0, 1, 8'h00);
    for (int i = 0; i < 2 * AB; i++) wr_cycle(0, 0, 1, 1, 8'(8'hA0 + i));

    // R5: a command abandons a partial group
    scen = "R5";
    wr_cycle(0, 1, 0, 1, 8'h60);
    for (int i = 0; i < 3; i++) wr_cycle(0, 0, 1, 1, 8'(8'hE0 + i));
    wr_cycle(0, 1, 0, 1, 8'h70);
    for (int i = 0; i < AB; i++) wr_cycle(0, 0, 1, 1, 8'(8'h40 + i));

    // R6: discarded strobes leave no trace and no count change
    scen = "R6";
    wr_cycle(0, 1, 0, 1, 8'h85);
    wr_cycle(0, 0, 1, 1, 8'h21);
    wr_cycle(0, 0, 1, 1, 8'h22);
    wr_cycle(1, 0, 1, 1, 8'h99);              // deselected
    wr_cycle(0, 1, 1, 1, 8'h98);              // both latches
    wr_cycle(0, 0, 1, 0, 8'h97);              // read strobe low
    wr_cycle(1, 1, 0, 1, 8'h96);              // deselected command
    wr_cycle(1, 0, 0, 1, 8'h95);              // deselected data
    for (int i = 0; i < 3; i++) wr_cycle(0, 0, 1, 1, 8'(8'h23 + i));

    // R7, R8: read pulses in and out of the read state
    scen = "R7";
    rd_pulse(1);
    rd_pulse(1, 5);
    rd_pulse(1, FILT);
    rd_pulse(0);                              // command latch high: not a read
    rd_pulse(1);

    // R9: glitches on both strobes
    scen = "R9";
    wr_cycle(0, 1, 0, 1, 8'h11, 1);           // one-clock write glitch
    @(negedge clk);
    sel_n = 1'b0; cl = 1'b1; dqi = 8'h22;
    #1 wn = 1'b0;
    #1 wn = 1'b1;                             // sub-clock write glitch
    repeat (3) @(negedge clk);
    idle();
    rd_pulse(1, 1);                           // one-clock read glitch
    wr_cycle(0, 1, 0, 1, 8'h90);
    wr_cycle(0, 0, 1, 1, 8'h01);
    wr_cycle(0, 0, 1, 1, 8'h02, 1);           // glitch inside a group
    for (int i = 0; i < AB - 1; i++) wr_cycle(0, 0, 1, 1, 8'(8'h03 + i));
    rd_pulse(1);

    repeat (12) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule